// File: doc/BRIEF.md
# Bridge Control Register File with Interrupt Steering

This block holds the control words of a host bridge: 28 words of 32 bits that cover power-on and general configuration, memory and I/O timing, address-map setup, GPIO, interrupt configuration, mailboxes and cache control. Software reaches it through a simple request bus. A byte address is turned into a word index by subtracting the window base 0x100 and dropping the two low bits. Only whole, aligned 32-bit accesses are accepted. Every read request gets a response one cycle later.

The interrupt enable word cannot be written directly. Software changes it by writing to a separate set word and a separate clear word, and each of those words also keeps the last value written to it. A rising edge of bit 2 in the general configuration word produces a one-cycle system reset request.

Interrupt events arrive as a strobe carrying a system interrupt number. Internal line n is system number 32 + n. For each accepted event, the block drives the CPU interrupt output in one of two ways, chosen by the edge and polarity configuration words: a single-cycle pulse, or a held level.

Top module: `bridge_ctl_regs`

## Requirements
- R1: After synchronous reset, reads return these values by word offset: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. Every other offset in 0x00–0x6C reads 0, and `cpu_irq` and `sys_rst_req` are 0.
- R2: The register at byte address 0x100 + offset is reachable for offsets 0x00–0x6C. A write to any offset other than 0x38 and 0x3C stores all 32 bits, and a later read returns them. Every read request raises `rsp_valid` with the data in the following cycle.
- R3: A write to offset 0x30 stores the value at 0x30 and ORs it into the enable word at 0x38.
- R4: A write to offset 0x34 stores the value at 0x34 and clears, in the enable word at 0x38, every bit that is 1 in the value.
- R5: The following writes change no register:
  - writes to 0x38 (enable) and 0x3C (status, which always reads 0);
  - writes to addresses below 0x100;
  - writes to addresses above 0x16C.
  Reads of addresses outside 0x100–0x16C return 0.
- R6: An access with `bus_full`=0, or with a byte address whose bits [1:0] are not 00, is rejected. A rejected write changes nothing, and a rejected read returns 0.
- R7: When a write to offset 0x04 changes bit 2 from 0 to 1, `sys_rst_req` is 1 for exactly the cycle after the write, and the value is stored. Any other write to 0x04 leaves `sys_rst_req` at 0.
- R8: An interrupt event with number 32 + n, where bit n of the edge word at 0x24 is 1, makes `cpu_irq` 1 in the cycle after the event and 0 in the cycle after that, unless another event arrives.
- R9: An interrupt event with number 32 + n, where bit n of the edge word is 0, sets `cpu_irq` in the next cycle to bit n of the polarity word at 0x2C. The output holds that level until the next accepted event.
- R10: Interrupt events with a number below 32 are ignored, and `cpu_irq` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_full | input | 1 | 1 = full 32-bit access |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Read response data |
| irq_valid | input | 1 | Interrupt event strobe |
| irq_num | input | IRQ_W (6) | System interrupt number |
| cpu_irq | output | 1 | CPU interrupt output |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertion that ignored interrupt events leave `cpu_irq` unchanged assumes that no edge pulse is still pending. The bench meets this by spacing every interrupt event at least two cycles after the one before it. The read-response and reset-request assertions assume at most one bus request per cycle, with each request held for exactly one cycle; the bench's bus tasks drive only that pattern. Expected register contents come from a word model in the bench. That model is updated only by the set, clear and store rules stated in the requirements.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 28;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int REG_BASE = 'h100;
    localparam int LINE_W   = $clog2(DATA_W);
    localparam int IRQ_BASE = 32;
    localparam int RST_BIT  = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // word indices that carry behaviour
    localparam idx_t IX_PWRON  = idx_t'(0);
    localparam idx_t IX_GENCFG = idx_t'(1);
    localparam idx_t IX_IOCFG  = idx_t'(2);
    localparam idx_t IX_MEMCFG = idx_t'(3);
    localparam idx_t IX_MAPCFG = idx_t'(4);
    localparam idx_t IX_GPDAT  = idx_t'(7);
    localparam idx_t IX_GPIEN  = idx_t'(8);
    localparam idx_t IX_EDGE   = idx_t'(9);
    localparam idx_t IX_POL    = idx_t'(11);
    localparam idx_t IX_ENSET  = idx_t'(12);
    localparam idx_t IX_ENCLR  = idx_t'(13);
    localparam idx_t IX_EN     = idx_t'(14);
    localparam idx_t IX_STAT   = idx_t'(15);
    localparam idx_t IX_DQCFG  = idx_t'(26);
    localparam idx_t IX_MEMSZ  = idx_t'(27);

    // accepted, decoded access
    typedef struct packed {
        logic  wr;
        logic  rd;
        idx_t  idx;
        word_t data;
    } acc_t;

    function automatic word_t reset_value(idx_t i);
        case (i)
            IX_PWRON:  return word_t'(32'h0000_0C40);
            IX_GENCFG: return word_t'(32'h0000_1384);
            IX_IOCFG:  return word_t'(32'h2BFF_8010);
            IX_MEMCFG: return word_t'(32'h255E_0091);
            IX_MAPCFG: return word_t'(32'h0000_6140);
            IX_GPDAT:  return word_t'(32'h0000_01FF);
            IX_GPIEN:  return word_t'(32'h0000_01FF);
            IX_DQCFG:  return word_t'(32'h0000_0008);
            IX_MEMSZ:  return word_t'(32'h1000_0000);
            default:   return '0;
        endcase
    endfunction

    // words that take the written value directly
    function automatic logic storable(idx_t i);
        return (i != IX_EN) && (i != IX_STAT);
    endfunction
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              valid,
    input  logic              write,
    input  logic              full,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output acc_t              acc
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(REG_BASE);
    localparam logic [ADDR_W-3:0] LIMIT  = (ADDR_W-2)'(NUM_REGS);

    logic [ADDR_W-1:0] off;
    logic              hit;

    always_comb begin
        off = addr - BASE_A;
        hit = valid && full && (addr[1:0] == 2'b00) && (addr >= BASE_A)
              && (off[ADDR_W-1:2] < LIMIT);
        acc.wr   = hit && write;
        acc.rd   = hit && !write;
        acc.idx  = off[IDX_W+1:2];
        acc.data = wdata;
    end
endmodule

// File: rtl/bcr_regfile.sv
module bcr_regfile
    import bcr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  acc_t  acc,
    input  logic  rd_any,
    output logic  rsp_valid,
    output word_t rsp_rdata,
    output logic  rst_req,
    output word_t edge_cfg,
    output word_t pol_cfg
);
    word_t [NUM_REGS-1:0] regs_w;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        localparam idx_t GI = idx_t'(g);
        word_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= reset_value(GI);
            end else if (GI == IX_EN) begin
                if (acc.wr && acc.idx == IX_ENSET)
                    q <= q | acc.data;
                else if (acc.wr && acc.idx == IX_ENCLR)
                    q <= q & ~acc.data;
            end else if (acc.wr && acc.idx == GI && storable(GI)) begin
                q <= acc.data;
            end
        end
        assign regs_w[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rst_req   <= 1'b0;
        end else begin
            rsp_valid <= rd_any;
            rsp_rdata <= acc.rd ? regs_w[acc.idx] : '0;
            rst_req   <= acc.wr && (acc.idx == IX_GENCFG)
                         && !regs_w[IX_GENCFG][RST_BIT] && acc.data[RST_BIT];
        end
    end

    assign edge_cfg = regs_w[IX_EDGE];
    assign pol_cfg  = regs_w[IX_POL];

    word_t en_w, stat_w;
    assign en_w   = regs_w[IX_EN];
    assign stat_w = regs_w[IX_STAT];

    p_set_or_r3: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.idx == IX_ENSET) |=> ((en_w & $past(acc.data)) == $past(acc.data)));
    p_clr_and_r4: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.idx == IX_ENCLR) |=> ((en_w & $past(acc.data)) == '0));
    p_ro_words_r5: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && (acc.idx == IX_EN || acc.idx == IX_STAT)) |=> ($stable(en_w) && stat_w == '0));
    p_rst_req_src_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> (!$past(regs_w[IX_GENCFG][RST_BIT]) && regs_w[IX_GENCFG][RST_BIT]));
    p_rst_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
endmodule

// File: rtl/bcr_irq_steer.sv
module bcr_irq_steer
    import bcr_pkg::*;
#(
    parameter int IRQ_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_valid,
    input  logic [IRQ_W-1:0] irq_num,
    input  word_t            edge_cfg,
    input  word_t            pol_cfg,
    output logic             cpu_irq
);
    localparam logic [IRQ_W-1:0] BASE_N = IRQ_W'(IRQ_BASE);
    localparam logic [IRQ_W-1:0] SPAN_N = IRQ_W'(DATA_W);

    logic [IRQ_W-1:0]  diff;
    logic [LINE_W-1:0] line;
    logic              ev_ok;
    logic              pulse_q;

    always_comb begin
        diff  = irq_num - BASE_N;
        line  = diff[LINE_W-1:0];
        ev_ok = irq_valid && (irq_num >= BASE_N) && (diff < SPAN_N);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_irq <= 1'b0;
            pulse_q <= 1'b0;
        end else if (ev_ok) begin
            if (edge_cfg[line]) begin
                cpu_irq <= 1'b1;
                pulse_q <= 1'b1;
            end else begin
                cpu_irq <= pol_cfg[line];
                pulse_q <= 1'b0;
            end
        end else if (pulse_q) begin
            cpu_irq <= 1'b0;
            pulse_q <= 1'b0;
        end
    end

    p_edge_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_ok && edge_cfg[line]) |=> cpu_irq);
    p_pulse_end_r8: assert property (@(posedge clk) disable iff (rst)
        (pulse_q && !irq_valid) |=> !cpu_irq);
    p_level_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_ok && !edge_cfg[line]) |=> (cpu_irq == $past(pol_cfg[line])));
    p_low_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_num < BASE_N && !pulse_q) |=> $stable(cpu_irq));
endmodule

// File: rtl/bridge_ctl_regs.sv
module bridge_ctl_regs
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IRQ_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_full,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic              irq_valid,
    input  logic [IRQ_W-1:0]  irq_num,
    output logic              cpu_irq,
    output logic              sys_rst_req
);
    acc_t  acc;
    word_t edge_cfg, pol_cfg;

    bcr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .valid (bus_valid),
        .write (bus_write),
        .full  (bus_full),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .acc   (acc)
    );

    bcr_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .rd_any    (bus_valid && !bus_write),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rst_req   (sys_rst_req),
        .edge_cfg  (edge_cfg),
        .pol_cfg   (pol_cfg)
    );

    bcr_irq_steer #(.IRQ_W(IRQ_W)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .irq_valid (irq_valid),
        .irq_num   (irq_num),
        .edge_cfg  (edge_cfg),
        .pol_cfg   (pol_cfg),
        .cpu_irq   (cpu_irq)
    );

    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> rsp_valid);
    p_partial_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && !bus_full) |=> (rsp_rdata == '0));
endmodule

// File: tb/test_bridge_ctl_regs.sv
module test_bridge_ctl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_full = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq_valid = 1'b0;
    logic [5:0]  irq_num = '0;
    logic        cpu_irq, sys_rst_req;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] model [28];
    logic        last_req;

    always #5 clk = ~clk;

    bridge_ctl_regs i_bridge_ctl_regs (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_full(bus_full),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq_valid(irq_valid), .irq_num(irq_num),
        .cpu_irq(cpu_irq), .sys_rst_req(sys_rst_req)
    );

    function automatic logic [31:0] rv(int i);
        case (i)
            0: return 32'h0000_0C40;  1: return 32'h0000_1384;
            2: return 32'h2BFF_8010;  3: return 32'h255E_0091;
            4: return 32'h0000_6140;  7: return 32'h0000_01FF;
            8: return 32'h0000_01FF; 26: return 32'h0000_0008;
            27: return 32'h1000_0000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d, logic full = 1'b1);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_full = full; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; bus_full = 1;
        last_req = sys_rst_req;
    endtask

    task automatic bus_rd(string tag, logic [11:0] a, logic [31:0] exp, logic full = 1'b1);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_full = full; bus_addr = a;
        @(negedge clk);
        bus_valid = 0; bus_full = 1;
        chk({tag, " rsp_valid"}, {31'b0, rsp_valid}, 32'h1);
        chk(tag, rsp_rdata, exp);
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < 28; i++) bus_rd(tag, 12'h100 + 12'(i * 4), model[i]);
    endtask

    // fires one event, checks output one and two cycles later
    task automatic fire(string tag, logic [5:0] num, logic e1, logic e2);
        @(negedge clk);
        irq_valid = 1; irq_num = num;
        @(negedge clk);
        irq_valid = 0;
        chk({tag, " first"}, {31'b0, cpu_irq}, {31'b0, e1});
        @(negedge clk);
        chk({tag, " second"}, {31'b0, cpu_irq}, {31'b0, e2});
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] edge_p, pol_p;
        repeat (3) @(negedge clk);
        rst = 0;
        for (int i = 0; i < 28; i++) model[i] = rv(i);

        // R1 reset state
        @(negedge clk);
        chk("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
        chk("R1 sys_rst_req", {31'b0, sys_rst_req}, 32'h0);
        read_all("R1 reset value");

        // R2 store and read back, two patterns
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 28; i++) begin
                if (i == 1 || (i >= 12 && i <= 15)) continue;
                model[i] = (p == 0) ? (32'hA5C3_0000 ^ (32'(i) * 32'h0101_0101))
                                    : ~(32'h1234_5678 + 32'(i) * 32'h0003_0005);
                bus_wr(12'h100 + 12'(i * 4), model[i]);
            end
            read_all("R2 readback");
        end

        // R3 set port
        bus_wr(12'h130, 32'h0000_F00F); model[12] = 32'h0000_F00F; model[14] = 32'h0000_F00F;
        bus_rd("R3 enable after set", 12'h138, model[14]);
        bus_wr(12'h130, 32'h00F0_0003); model[12] = 32'h00F0_0003; model[14] = 32'h00F0_F00F;
        bus_rd("R3 set word stored", 12'h130, model[12]);
        bus_rd("R3 enable after second set", 12'h138, model[14]);
        // R4 clear port
        bus_wr(12'h134, 32'h0000_000F); model[13] = 32'h0000_000F; model[14] = 32'h00F0_F000;
        bus_rd("R4 clear word stored", 12'h134, model[13]);
        bus_rd("R4 enable after clear", 12'h138, model[14]);
        bus_wr(12'h134, 32'hFFFF_FFFF); model[13] = 32'hFFFF_FFFF; model[14] = 32'h0;
        bus_rd("R4 enable all cleared", 12'h138, 32'h0);
        bus_wr(12'h130, 32'h8000_0001); model[12] = 32'h8000_0001; model[14] = 32'h8000_0001;

        // R5 ignored writes and unknown reads
        bus_wr(12'h138, 32'h7FFF_FFFE);
        bus_wr(12'h13C, 32'hFFFF_FFFF);
        bus_wr(12'h170, 32'hDEAD_BEEF);
        bus_wr(12'h1FC, 32'hDEAD_BEEF);
        bus_wr(12'h0FC, 32'hDEAD_BEEF);
        bus_wr(12'h000, 32'hDEAD_BEEF);
        read_all("R5 unchanged after ignored writes");
        bus_rd("R5 unknown read 0x170", 12'h170, 32'h0);
        bus_rd("R5 unknown read 0x0FC", 12'h0FC, 32'h0);

        // R6 partial and unaligned accesses
        bus_wr(12'h140, 32'h1111_2222, 1'b0);
        bus_wr(12'h142, 32'h3333_4444);
        bus_rd("R6 partial read zero", 12'h140, 32'h0, 1'b0);
        bus_rd("R6 unaligned read zero", 12'h141, 32'h0);
        bus_rd("R6 word unchanged", 12'h140, model[16]);

        // R7 reset request on 0->1 of bit 2
        bus_wr(12'h104, 32'h0000_1384); model[1] = 32'h0000_1384;
        chk("R7 no request 1->1", {31'b0, last_req}, 32'h0);
        bus_wr(12'h104, 32'h0000_0000); model[1] = 32'h0;
        chk("R7 no request 1->0", {31'b0, last_req}, 32'h0);
        bus_wr(12'h104, 32'h0000_0004); model[1] = 32'h4;
        chk("R7 request on 0->1", {31'b0, last_req}, 32'h1);
        @(negedge clk);
        chk("R7 request one cycle", {31'b0, sys_rst_req}, 32'h0);
        bus_wr(12'h104, 32'h0000_00FC); model[1] = 32'hFC;
        chk("R7 no request still set", {31'b0, last_req}, 32'h0);
        bus_rd("R7 value stored", 12'h104, model[1]);

        // R8 / R9 sweep over all lines, two configurations
        for (int c = 0; c < 2; c++) begin
            edge_p = (c == 0) ? 32'h0F0F_33C5 : 32'hF0F0_CC3A;
            pol_p  = (c == 0) ? 32'h5A5A_A5A5 : 32'h3C3C_C3C3;
            bus_wr(12'h124, edge_p);
            bus_wr(12'h12C, pol_p);
            for (int n = 0; n < 32; n++) begin
                if (edge_p[n]) fire("R8 edge pulse", 6'(32 + n), 1'b1, 1'b0);
                else           fire("R9 level", 6'(32 + n), pol_p[n], pol_p[n]);
            end
        end

        // R10 numbers below 32 ignored
        bus_wr(12'h124, 32'h0);
        bus_wr(12'h12C, 32'hFFFF_FFFF);
        fire("R9 level high", 6'd35, 1'b1, 1'b1);
        fire("R10 ignored keeps high", 6'd3, 1'b1, 1'b1);
        bus_wr(12'h12C, 32'h0);
        fire("R9 level low", 6'd40, 1'b0, 1'b0);
        fire("R10 ignored keeps low", 6'd31, 1'b0, 1'b0);
        bus_wr(12'h124, 32'hFFFF_FFFF);
        fire("R10 ignored no pulse", 6'd0, 1'b0, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule